// File: doc/BRIEF.md
# Bounds-Checked Data Memory

A single-port word memory that serves a processor datapath as its data store. Program data and instructions are both kept as plain words. In any cycle the port performs at most one access, a read or a write. A read is combinational: the word at the presented address appears on the data output in the same cycle, the way a register file read behaves. A write is committed at the rising clock edge.

Every address is range-checked. The implemented depth is a parameter, while the address port is wider, so the port can present addresses that have no storage behind them. Such an address raises a combinational error flag in the same cycle and suppresses the access. An out-of-range write is dropped instead of wrapping onto a low word, and an out-of-range read returns zero. A request that asserts both read and write is also treated as an error and does nothing. While the active-low reset is held, writes are blocked. The stored contents are not cleared by reset.

The read and write controls are plain per-cycle strobes and the memory never stalls, so the port has no valid/ready handshake and no back-pressure.

Top module: `dmem_bounded`

## Requirements
- R1: With rd_en_i=1, wr_en_i=0 and addr_i below DEPTH, rdata_o equals the stored word at addr_i in the same cycle. It follows an address change without waiting for a clock edge.
- R2: With wr_en_i=1, rd_en_i=0, rst_n=1 and addr_i below DEPTH, wdata_i is stored at addr_i on the rising clock edge. A read of that address in a later cycle returns it.
- R3: A write to an address at or above DEPTH changes no stored word. This includes word (addr_i mod 2^IDX_W), which the address would otherwise alias onto.
- R4: err_o is combinational. It is 1 whenever addr_i >= DEPTH, whatever the controls are. For addresses 0 to DEPTH-1 it is 0 unless R5 applies. Defaults: DEPTH=1024 and WIDTH=32, so address 1023 is the last valid one, and ADDR_W=12.
- R5: When rd_en_i=1 and wr_en_i=1 together, err_o is 1, no word is written and rdata_o is 0.
- R6: rdata_o is 0 whenever rd_en_i=0 or err_o=1.
- R7: While rst_n=0, no write takes place. Contents written before reset survive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| rd_en_i | input | 1 | Read request for this cycle |
| wr_en_i | input | 1 | Write request for this cycle |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | WIDTH | Word to store |
| rdata_o | output | WIDTH | Word read, or zero |
| err_o | output | 1 | Address out of range or conflicting request |

## Verification
The checker assumes that the controls, the address and the write data are known, non-X values once reset is released. Its stability and read-back properties also assume that any in-range address being read has been written earlier, so the compared word is never undefined. The bench drives every input at the falling clock edge and always to defined values. It reads back only addresses it has written first, which keeps the stimulus inside those assumptions.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE     = 2'd0,
    ACC_READ     = 2'd1,
    ACC_WRITE    = 2'd2,
    ACC_CONFLICT = 2'd3
  } acc_e;

  function automatic acc_e classify(input logic rd, input logic wr);
    case ({rd, wr})
      2'b10:   return ACC_READ;
      2'b01:   return ACC_WRITE;
      2'b11:   return ACC_CONFLICT;
      default: return ACC_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/dmem_range_check.sv
module dmem_range_check
  import dmem_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 12
) (
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              err_o,
  output logic              we_o,
  output logic              rd_ok_o
);

  localparam int              SPAN  = 1 << ADDR_W;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(DEPTH);

  logic in_range;
  acc_e kind;

  generate
    if (DEPTH == SPAN) begin : g_full_span
      assign in_range = 1'b1;
    end else begin : g_partial_span
      assign in_range = ({1'b0, addr_i} < LIMIT);
    end
  endgenerate

  always_comb begin
    kind    = classify(rd_en_i, wr_en_i);
    err_o   = !in_range || (kind == ACC_CONFLICT);
    we_o    = rst_n && in_range && (kind == ACC_WRITE);
    rd_ok_o = in_range && (kind == ACC_READ);
  end

endmodule

// File: rtl/dmem_store.sv
module dmem_store #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 32,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] word_o
);

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      cells[idx_i] <= wdata_i;
    end
  end

  assign word_o = cells[idx_i];

endmodule

// File: rtl/dmem_rd_mux.sv
module dmem_rd_mux #(
  parameter int WIDTH = 32
) (
  input  logic             rd_ok_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] rdata_o
);

  always_comb begin
    rdata_o = rd_ok_i ? word_i : '0;
  end

endmodule

// File: rtl/dmem_bounded.sv
module dmem_bounded #(
  parameter int DEPTH  = 1024,
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic              err_o
);

  localparam int IDX_W = $clog2(DEPTH);

  logic             we;
  logic             rd_ok;
  logic [WIDTH-1:0] word;

  dmem_range_check #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) range_i (
    .rst_n   (rst_n),
    .rd_en_i (rd_en_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .err_o   (err_o),
    .we_o    (we),
    .rd_ok_o (rd_ok)
  );

  dmem_store #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH),
    .IDX_W (IDX_W)
  ) store_i (
    .clk     (clk),
    .we_i    (we),
    .idx_i   (addr_i[IDX_W-1:0]),
    .wdata_i (wdata_i),
    .word_o  (word)
  );

  dmem_rd_mux #(
    .WIDTH (WIDTH)
  ) mux_i (
    .rd_ok_i (rd_ok),
    .word_i  (word),
    .rdata_o (rdata_o)
  );

endmodule

// File: rtl/dmem_bounded_chk.sv
module dmem_bounded_chk #(
  parameter int DEPTH  = 1024,
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  rdata_o,
  input logic              err_o
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(DEPTH);

  logic oob;
  logic clean_rd;
  logic clean_wr;

  assign oob      = ({1'b0, addr_i} >= LIMIT);
  assign clean_rd = rd_en_i && !wr_en_i && !err_o;
  assign clean_wr = wr_en_i && !rd_en_i && !err_o;

  // R4: an address past the last word always raises the flag
  p_oob_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oob |-> err_o);

  // R4: an in-range address with a single request raises no flag
  p_inrange_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!oob && !(rd_en_i && wr_en_i)) |-> !err_o);

  // R5: simultaneous requests are an error with zero read data
  p_conflict_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && wr_en_i) |-> (err_o && rdata_o == '0));

  // R6: no read request or an error means zero on the output
  p_rdata_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_i || err_o) |-> (rdata_o == '0));

  // R2: a clean write is returned by a later read of the same address
  p_write_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clean_wr) && $past(rst_n) && clean_rd && addr_i == $past(addr_i))
      |-> (rdata_o == $past(wdata_i)));

  // R3, R5: a word changes only after a clean write
  p_word_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clean_rd) && clean_rd && addr_i == $past(addr_i)
      && !$past(clean_wr)) |-> $stable(rdata_o));

endmodule

bind dmem_bounded dmem_bounded_chk #(
  .DEPTH  (DEPTH),
  .WIDTH  (WIDTH),
  .ADDR_W (ADDR_W)
) chk_i (.*);

// File: tb/dmem_bounded_tb_top.sv
module dmem_bounded_tb_top;

  localparam int DEPTH  = 1024;
  localparam int WIDTH  = 32;
  localparam int ADDR_W = 12;
  localparam int MAX_CYCLES = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rd_en = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [WIDTH-1:0]  wdata = '0;
  logic [WIDTH-1:0]  rdata;
  logic              err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dmem_bounded #(
    .DEPTH  (DEPTH),
    .WIDTH  (WIDTH),
    .ADDR_W (ADDR_W)
  ) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en_i (rd_en),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .err_o   (err)
  );

  task automatic check(input string req, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic rd, input logic wr,
                       input logic [ADDR_W-1:0] a, input logic [WIDTH-1:0] d);
    @(negedge clk);
    rd_en = rd;
    wr_en = wr;
    addr  = a;
    wdata = d;
    #1;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [WIDTH-1:0] d);
    drive(1'b0, 1'b1, a, d);
  endtask

  task automatic expect_read(input string req, input logic [ADDR_W-1:0] a,
                             input logic [WIDTH-1:0] exp);
    drive(1'b1, 1'b0, a, '0);
    check(req, rdata, exp);
    check(req, {31'd0, err}, 32'd0);
  endtask

  task automatic t_reset_state;
    #1;
    check("R6 reset rdata", rdata, '0);
    check("R4 reset err", {31'd0, err}, 32'd0);
  endtask

  task automatic t_read_after_write;
    do_write(12'd0, 32'hA5A5_0000);
    do_write(12'd1, 32'h0000_5A5A);
    do_write(12'd1023, 32'hDEAD_BEEF);
    do_write(12'd512, 32'hFFFF_FFFF);
    expect_read("R2 addr0", 12'd0, 32'hA5A5_0000);
    expect_read("R2 addr1", 12'd1, 32'h0000_5A5A);
    expect_read("R2 last", 12'd1023, 32'hDEAD_BEEF);
    expect_read("R2 mid", 12'd512, 32'hFFFF_FFFF);
    do_write(12'd1, 32'h1234_5678);
    expect_read("R2 overwrite", 12'd1, 32'h1234_5678);
  endtask

  task automatic t_comb_read;
    drive(1'b1, 1'b0, 12'd0, '0);
    check("R1 first addr", rdata, 32'hA5A5_0000);
    addr = 12'd1023;
    #1;
    check("R1 same-cycle follow", rdata, 32'hDEAD_BEEF);
  endtask

  task automatic t_idle;
    drive(1'b0, 1'b0, 12'd0, 32'h1111_1111);
    check("R6 idle rdata", rdata, '0);
    check("R4 idle err", {31'd0, err}, 32'd0);
    expect_read("R6 idle no write", 12'd0, 32'hA5A5_0000);
  endtask

  task automatic t_conflict;
    do_write(12'd7, 32'h0707_0707);
    drive(1'b1, 1'b1, 12'd7, 32'hBAD0_BAD0);
    check("R5 conflict err", {31'd0, err}, 32'd1);
    check("R5 conflict rdata", rdata, '0);
    expect_read("R5 conflict no write", 12'd7, 32'h0707_0707);
  endtask

  task automatic t_bounds;
    drive(1'b1, 1'b0, 12'd1023, '0);
    check("R4 last valid err", {31'd0, err}, 32'd0);
    drive(1'b1, 1'b0, 12'd1024, '0);
    check("R4 first invalid err", {31'd0, err}, 32'd1);
    check("R6 oob read zero", rdata, '0);
    drive(1'b0, 1'b0, 12'd4095, '0);
    check("R4 max addr err idle", {31'd0, err}, 32'd1);
    drive(1'b0, 1'b1, 12'd1024, 32'hCAFE_CAFE);
    check("R4 oob write err", {31'd0, err}, 32'd1);
    drive(1'b0, 1'b1, 12'd2047, 32'hCAFE_F00D);
    expect_read("R3 alias word0 intact", 12'd0, 32'hA5A5_0000);
    expect_read("R3 alias word1023 intact", 12'd1023, 32'hDEAD_BEEF);
  endtask

  task automatic t_reset_block;
    do_write(12'd5, 32'h5555_AAAA);
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b1;
    rd_en = 1'b0;
    addr  = 12'd5;
    wdata = 32'h0BAD_0BAD;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b1;
    expect_read("R7 write blocked in reset", 12'd5, 32'h5555_AAAA);
  endtask

  initial begin
    t_reset_state();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_read_after_write();
    t_comb_read();
    t_idle();
    t_conflict();
    t_bounds();
    t_reset_block();
    drive(1'b0, 1'b0, '0, '0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule